// File: doc/BRIEF.md
# JTAG Host Scan Shifter

This block is the host side of a four-wire test access port. It generates the test clock, drives the mode-select and data-in pins, and samples the data-out pin of an attached scan chain. Software or a higher-level sequencer gives it one shift command at a time over a valid/ready handshake. A command carries a bit count of 1 to 32, a word of mode-select bits, a word of data-in bits and a flag that asks for the data-out bits to be kept. When the last bit has been clocked, the block returns the captured word with a one-cycle done pulse.

The test clock is an integer division of the system clock. The divisor is latched when a command is accepted. The clock idles low. Mode-select and data-in change on the falling test-clock edge, and data-out is sampled on the rising edge. Every driven pin has an output enable. The enables stay off after reset and come on only when the port enable input is raised. Dropping the port enable in the middle of a command abandons it: the test clock returns low first, and only then are the enables released.

Top module: `jtag_scan_host`

## Requirements
- R1: After reset, tck_oe, tms_oe and tdi_oe are 0, tck_o is 0, rsp_valid is 0 and cmd_ready is 0.
- R2: One cycle after port_en is sampled high, all three output enables are 1. They stay 1 for as long as port_en stays high.
- R3: cmd_ready is 1 only when port_en is high, the enables are on and no command is in progress. It is 0 for the whole of a shift.
- R4: With divisor value D in div_cfg, each test-clock period lasts D system cycles. The high phase lasts floor(D/2) cycles and the low phase takes the rest, so an odd D makes the low phase one cycle longer. D values of 0 and 1 both give the fastest period of 2 cycles (1 high, 1 low). The first low phase begins in the cycle a command is accepted.
- R5: tms_o and tdi_o change only while tck_o is low. The first bit is presented on acceptance, and each later bit is presented on the system edge that takes tck_o low.
- R6: A command makes exactly cmd_len+1 rising test-clock edges, so cmd_len holds the bit count minus one. During the k-th pulse (k counted from 0), tms_o equals bit k of cmd_tms and tdi_o equals bit k of cmd_tdi, least significant bit first.
- R7: When cmd_cap is 1, bit k of rsp_tdo is the value of tdo_i at the k-th rising test-clock edge, and bits beyond the count are 0. When cmd_cap is 0, rsp_tdo is all zero.
- R8: rsp_valid pulses for one cycle per completed command. It is set on the same system edge that takes tck_o low after the final pulse, and cmd_ready is 1 in that same cycle.
- R9: If port_en drops during a command, tck_o is 0 in the next cycle and no rsp_valid follows for that command. The output enables fall only once tck_o is already 0.
- R10: The divisor is latched on acceptance. Changing div_cfg while a command runs does not alter that command's phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the base of the test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Enables pin drive and command acceptance |
| div_cfg | input | DIV_W | Test-clock divisor, latched per command |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command may be accepted |
| cmd_len | input | LEN_W | Bit count minus one |
| cmd_tms | input | MAX_BITS | Mode-select bits, bit 0 first |
| cmd_tdi | input | MAX_BITS | Data-in bits, bit 0 first |
| cmd_cap | input | 1 | Keep the sampled data-out bits |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_tdo | output | MAX_BITS | Captured data-out word |
| tck_o | output | 1 | Test clock value |
| tck_oe | output | 1 | Test clock drive enable |
| tms_o | output | 1 | Mode-select value |
| tms_oe | output | 1 | Mode-select drive enable |
| tdi_o | output | 1 | Data-in value |
| tdi_oe | output | 1 | Data-in drive enable |
| tdo_i | input | 1 | Data-out from the scan chain |

## Verification
A phase counter loaded with the wrong length shows up within one test-clock period as a high or low run of the wrong size. A corrupted bit index or shift register shows up at the very next rising edge as a wrong mode-select or data-in value, or at the end of the command as a wrong pulse count or captured word. A sequencer that misses an abort gives either a done pulse that should never come, or an enable that drops while the clock is still high, and either is visible within two cycles of port_en falling.

// File: rtl/jtag_host_pkg.sv
package jtag_host_pkg;

   typedef enum logic [1:0] {
      SH_IDLE = 2'd0,
      SH_LOW  = 2'd1,
      SH_HIGH = 2'd2
   } shift_state_e;

   // Smallest test-clock period a registered clock pin can produce.
   localparam int unsigned MIN_PERIOD = 2;

endpackage

// File: rtl/jtag_tck_timer.sv
module jtag_tck_timer #(
   parameter int unsigned DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             div_load,
   input  logic [DIV_W-1:0] div_in,
   input  logic             arm_low,
   input  logic             arm_high,
   output logic             expired
);
   import jtag_host_pkg::*;

   localparam logic [DIV_W-1:0] PERIOD_MIN = DIV_W'(MIN_PERIOD);

   logic [DIV_W-1:0] eff_div;
   logic [DIV_W-1:0] new_hi, new_lo;
   logic [DIV_W-1:0] hi_q, lo_q;
   logic [DIV_W-1:0] cnt_q;

   always_comb begin
      eff_div = (div_in < PERIOD_MIN) ? PERIOD_MIN : div_in;
      new_hi  = eff_div >> 1;
      new_lo  = eff_div - new_hi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= DIV_W'(1);
         lo_q  <= DIV_W'(1);
         cnt_q <= '0;
      end else begin
         if (div_load) begin
            hi_q <= new_hi;
            lo_q <= new_lo;
         end
         if (arm_low)
            cnt_q <= (div_load ? new_lo : lo_q) - DIV_W'(1);
         else if (arm_high)
            cnt_q <= hi_q - DIV_W'(1);
         else if (cnt_q != '0)
            cnt_q <= cnt_q - DIV_W'(1);
      end
   end

   assign expired = (cnt_q == '0);

   // R4: a phase of length one or more expires before it is re-armed
   assert_phase_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_high && !div_load) |-> (hi_q != '0));

endmodule

// File: rtl/jtag_pin_oe.sv
module jtag_pin_oe #(
   parameter int unsigned N_PINS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              tck_level,
   output logic [N_PINS-1:0] oe
);
   logic oe_q;

   // Hold the drive while the clock is still high so it can be parked low.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= port_en | (oe_q & tck_level);
   end

   for (genvar p = 0; p < N_PINS; p++) begin : g_oe
      assign oe[p] = oe_q;
   end

   // R2: enable follows port_en one cycle later
   assert_oe_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      port_en |=> oe_q);

   // R9: drive is released only when the clock already sits low
   assert_release_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_q) |-> !tck_level);

endmodule

// File: rtl/jtag_shift_seq.sv
module jtag_shift_seq #(
   parameter int unsigned MAX_BITS = 32,
   parameter int unsigned LEN_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                port_en,
   input  logic                oe_on,
   input  logic                cmd_valid,
   output logic                cmd_ready,
   input  logic [LEN_W-1:0]    cmd_len,
   input  logic [MAX_BITS-1:0] cmd_tms,
   input  logic [MAX_BITS-1:0] cmd_tdi,
   input  logic                cmd_cap,
   input  logic                tdo_i,
   input  logic                tmr_last,
   output logic                div_load,
   output logic                arm_low,
   output logic                arm_high,
   output logic                tck_o,
   output logic                tms_o,
   output logic                tdi_o,
   output logic                rsp_valid,
   output logic [MAX_BITS-1:0] rsp_tdo
);
   import jtag_host_pkg::*;

   shift_state_e        state_q;
   logic [MAX_BITS-1:0] sh_tms_q, sh_tdi_q, cap_q;
   logic [LEN_W-1:0]    len_q, idx_q;
   logic                cap_en_q;
   logic                tck_q, tms_q, tdi_q, rsp_q;
   logic [MAX_BITS-1:0] rsp_tdo_q;
   logic                accept, last_bit, rise_now, fall_now;

   always_comb begin
      cmd_ready = port_en && oe_on && (state_q == SH_IDLE);
      accept    = cmd_valid && cmd_ready;
      last_bit  = (idx_q == len_q);
      rise_now  = port_en && (state_q == SH_LOW)  && tmr_last;
      fall_now  = port_en && (state_q == SH_HIGH) && tmr_last;
      div_load  = accept;
      arm_low   = accept || (fall_now && !last_bit);
      arm_high  = rise_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SH_IDLE;
         sh_tms_q  <= '0;
         sh_tdi_q  <= '0;
         cap_q     <= '0;
         len_q     <= '0;
         idx_q     <= '0;
         cap_en_q  <= 1'b0;
         tck_q     <= 1'b0;
         tms_q     <= 1'b1;
         tdi_q     <= 1'b0;
         rsp_q     <= 1'b0;
         rsp_tdo_q <= '0;
      end else begin
         rsp_q <= 1'b0;
         if (!port_en) begin
            state_q <= SH_IDLE;
            tck_q   <= 1'b0;
         end else begin
            unique case (state_q)
               SH_IDLE: if (accept) begin
                  sh_tms_q <= cmd_tms;
                  sh_tdi_q <= cmd_tdi;
                  tms_q    <= cmd_tms[0];
                  tdi_q    <= cmd_tdi[0];
                  len_q    <= cmd_len;
                  cap_en_q <= cmd_cap;
                  idx_q    <= '0;
                  cap_q    <= '0;
                  tck_q    <= 1'b0;
                  state_q  <= SH_LOW;
               end
               SH_LOW: if (tmr_last) begin
                  tck_q   <= 1'b1;
                  if (cap_en_q) cap_q[idx_q] <= tdo_i;
                  state_q <= SH_HIGH;
               end
               SH_HIGH: if (tmr_last) begin
                  tck_q <= 1'b0;
                  if (last_bit) begin
                     state_q   <= SH_IDLE;
                     rsp_q     <= 1'b1;
                     rsp_tdo_q <= cap_q;
                  end else begin
                     sh_tms_q <= sh_tms_q >> 1;
                     sh_tdi_q <= sh_tdi_q >> 1;
                     tms_q    <= sh_tms_q[1];
                     tdi_q    <= sh_tdi_q[1];
                     idx_q    <= idx_q + LEN_W'(1);
                     state_q  <= SH_LOW;
                  end
               end
               default: state_q <= SH_IDLE;
            endcase
         end
      end
   end

   assign tck_o     = tck_q;
   assign tms_o     = tms_q;
   assign tdi_o     = tdi_q;
   assign rsp_valid = rsp_q;
   assign rsp_tdo   = rsp_tdo_q;

   // R5: launched values never move while the clock is high
   assert_launch_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(tms_q) || !$stable(tdi_q)) |-> !tck_q);

   // R3: a ready port has its clock parked low
   assert_ready_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !tck_q);

   // R8: completion coincides with the closing falling edge
   assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_q |-> $fell(tck_q));

   // R9: losing the port enable parks the clock at once
   assert_abort_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> (!tck_q && !rsp_q));

endmodule

// File: rtl/jtag_scan_host.sv
module jtag_scan_host #(
   parameter int unsigned DIV_W    = 12,
   parameter int unsigned MAX_BITS = 32,
   parameter int unsigned LEN_W    = $clog2(MAX_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                port_en,
   input  logic [DIV_W-1:0]    div_cfg,
   input  logic                cmd_valid,
   output logic                cmd_ready,
   input  logic [LEN_W-1:0]    cmd_len,
   input  logic [MAX_BITS-1:0] cmd_tms,
   input  logic [MAX_BITS-1:0] cmd_tdi,
   input  logic                cmd_cap,
   output logic                rsp_valid,
   output logic [MAX_BITS-1:0] rsp_tdo,
   output logic                tck_o,
   output logic                tck_oe,
   output logic                tms_o,
   output logic                tms_oe,
   output logic                tdi_o,
   output logic                tdi_oe,
   input  logic                tdo_i
);
   localparam int unsigned N_PINS = 3;

   if (DIV_W < 2) begin : g_bad_div
      $error("DIV_W must be at least 2");
   end
   if (MAX_BITS < 2) begin : g_bad_bits
      $error("MAX_BITS must be at least 2");
   end
   if ((1 << LEN_W) < MAX_BITS) begin : g_bad_len
      $error("LEN_W too narrow for MAX_BITS");
   end

   logic              div_load, arm_low, arm_high, tmr_last;
   logic [N_PINS-1:0] oe_vec;

   jtag_tck_timer #(.DIV_W(DIV_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_load (div_load),
      .div_in   (div_cfg),
      .arm_low  (arm_low),
      .arm_high (arm_high),
      .expired  (tmr_last)
   );

   jtag_shift_seq #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .port_en   (port_en),
      .oe_on     (oe_vec[0]),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .cmd_len   (cmd_len),
      .cmd_tms   (cmd_tms),
      .cmd_tdi   (cmd_tdi),
      .cmd_cap   (cmd_cap),
      .tdo_i     (tdo_i),
      .tmr_last  (tmr_last),
      .div_load  (div_load),
      .arm_low   (arm_low),
      .arm_high  (arm_high),
      .tck_o     (tck_o),
      .tms_o     (tms_o),
      .tdi_o     (tdi_o),
      .rsp_valid (rsp_valid),
      .rsp_tdo   (rsp_tdo)
   );

   jtag_pin_oe #(.N_PINS(N_PINS)) u_oe (
      .clk       (clk),
      .rst_n     (rst_n),
      .port_en   (port_en),
      .tck_level (tck_o),
      .oe        (oe_vec)
   );

   assign tck_oe = oe_vec[0];
   assign tms_oe = oe_vec[1];
   assign tdi_oe = oe_vec[2];

endmodule

// File: tb/jtag_scan_host_tb.sv
module jtag_scan_host_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        port_en = 1'b0;
   logic [11:0] div_cfg = '0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [4:0]  cmd_len = '0;
   logic [31:0] cmd_tms = '0, cmd_tdi = '0;
   logic        cmd_cap = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_tdo;
   logic        tck_o, tck_oe, tms_o, tms_oe, tdi_o, tdi_oe;
   logic        tdo_i = 1'b0;

   int checks = 0, errors = 0;
   bit done_all = 0;

   always #4 clk = ~clk;

   jtag_scan_host u_dut (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .div_cfg(div_cfg),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_len(cmd_len),
      .cmd_tms(cmd_tms), .cmd_tdi(cmd_tdi), .cmd_cap(cmd_cap),
      .rsp_valid(rsp_valid), .rsp_tdo(rsp_tdo),
      .tck_o(tck_o), .tck_oe(tck_oe), .tms_o(tms_o), .tms_oe(tms_oe),
      .tdi_o(tdi_o), .tdi_oe(tdi_oe), .tdo_i(tdo_i)
   );

   // expected state of the running command
   logic [31:0] exp_tms, exp_tdi, pat;
   int          exp_len, exp_h, exp_l, pidx;
   bit          aborting = 0;
   logic [31:0] exp_q[$];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pulse-by-pulse checks and scoreboard pop
   logic prev_tck = 1'b0;
   int   hi_run = 0, lo_run = 0;
   always @(negedge clk) if (rst_n) begin
      if (tck_o && !prev_tck) begin
         if (pidx < 32) begin
            check("R6 tms bit", {31'b0, tms_o}, {31'b0, exp_tms[pidx]});
            check("R6 tdi bit", {31'b0, tdi_o}, {31'b0, exp_tdi[pidx]});
         end
         if (pidx > 0 && !aborting) check("R4 low phase", lo_run, exp_l);
         pidx++;
         if (pidx < 32) tdo_i = pat[pidx];
         hi_run = 1;
      end else if (tck_o) begin
         hi_run++;
      end else if (prev_tck) begin
         if (!aborting) check("R4 high phase", hi_run, exp_h);
         lo_run = 1;
      end else begin
         lo_run++;
      end
      prev_tck = tck_o;
      if (rsp_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R9 unexpected rsp_valid actual=1 expected=0");
         end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check("R7 captured word", rsp_tdo, e);
            check("R6 pulse count", pidx, exp_len);
            check("R8 tck low at done", {31'b0, tck_o}, 32'd0);
            check("R8 ready with done", {31'b0, cmd_ready}, 32'd1);
         end
      end
   end

   task automatic start_shift(input int lm1, input logic [31:0] tms, input logic [31:0] tdi,
                              input logic [31:0] p, input logic cap, input int dv);
      int eff;
      logic [31:0] mask;
      eff = (dv < 2) ? 2 : dv;
      mask = (lm1 == 31) ? 32'hFFFF_FFFF : ((32'd1 << (lm1 + 1)) - 32'd1);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      exp_tms = tms; exp_tdi = tdi; pat = p; exp_len = lm1 + 1;
      exp_h = eff / 2; exp_l = eff - exp_h;
      pidx = 0; tdo_i = p[0];
      div_cfg = dv[11:0]; cmd_len = lm1[4:0]; cmd_tms = tms; cmd_tdi = tdi; cmd_cap = cap;
      cmd_valid = 1'b1;
      exp_q.push_back(cap ? (p & mask) : 32'd0);
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R3 ready low during shift", {31'b0, cmd_ready}, 32'd0);
   endtask

   task automatic wait_done();
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_all) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 tck_oe", {31'b0, tck_oe}, 32'd0);
      check("R1 tms_oe", {31'b0, tms_oe}, 32'd0);
      check("R1 tdi_oe", {31'b0, tdi_oe}, 32'd0);
      check("R1 tck", {31'b0, tck_o}, 32'd0);
      check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
      check("R1 ready", {31'b0, cmd_ready}, 32'd0);

      port_en = 1'b1;
      @(negedge clk);
      // R2 enables one cycle later
      check("R2 enables", {29'b0, tck_oe, tms_oe, tdi_oe}, 32'd7);
      check("R3 ready when enabled", {31'b0, cmd_ready}, 32'd1);

      // R6 R7 even divisor
      start_shift(7, 32'h0000_00A5, 32'h0000_003C, 32'h0000_00D2, 1'b1, 4);
      wait_done();
      // R4 odd divisor, full length
      start_shift(31, 32'h1234_5678, 32'hCAFE_F00D, 32'h8BAD_F00D, 1'b1, 5);
      wait_done();
      // R4 divisor 0 -> period 2, single bit
      start_shift(0, 32'h1, 32'h0, 32'h1, 1'b1, 0);
      wait_done();
      // R7 capture disabled, divisor 1
      start_shift(4, 32'h15, 32'h0A, 32'h1F, 1'b0, 1);
      wait_done();
      // R10 divisor change mid-shift ignored
      start_shift(11, 32'h0F0, 32'hA5A, 32'h3C3, 1'b1, 6);
      div_cfg = 12'd3;
      wait_done();
      check("R2 enables held", {29'b0, tck_oe, tms_oe, tdi_oe}, 32'd7);

      // R9 abort while TCK is high
      start_shift(31, 32'hFFFF_0000, 32'h0000_FFFF, 32'h5555_5555, 1'b1, 10);
      while (!(tck_o && pidx >= 3)) @(negedge clk);
      aborting = 1;
      port_en = 1'b0;
      exp_q.delete();
      @(negedge clk);
      check("R9 tck parked", {31'b0, tck_o}, 32'd0);
      check("R9 enable held while parking", {31'b0, tck_oe}, 32'd1);
      @(negedge clk);
      check("R9 enables released", {29'b0, tck_oe, tms_oe, tdi_oe}, 32'd0);
      repeat (40) @(negedge clk);
      check("R3 ready off when disabled", {31'b0, cmd_ready}, 32'd0);
      check("R9 tck stays low", {31'b0, tck_o}, 32'd0);
      aborting = 0;
      port_en = 1'b1;
      start_shift(2, 32'h5, 32'h2, 32'h6, 1'b1, 2);
      wait_done();

      repeat (5) @(negedge clk);
      done_all = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule